// File: doc/BRIEF.md
# Predicated Integer Outer-Product Tile Accumulator

This block runs one integer outer-product-and-accumulate pass over a square tile of VL×VL 64-bit words. The tile lives inside the block. The caller presents two vectors of VL 64-bit words, called A and B, and one predicate byte for each word of each vector. It also presents a 5-bit operation word, then pulses `start`. The block latches all of these inputs. It then visits every tile word with the row index in the outer loop and the column index in the inner loop, one word per clock cycle. Each word is replaced by the lane result built from A[row], B[col], the old word, and the AND of the row and column predicate bytes.

The lane works in one of two ways. In the byte form, eight byte products are split into two groups of four, and each group accumulates into its own 32-bit half of the tile word. In the halfword form, four halfword products accumulate into the full 64-bit word. Each operand can be signed or unsigned on its own, and the whole pass can subtract instead of add. While idle, a clear input empties the tile. A combinational read port exposes any tile word.

Top module: `outer_tile_mac`

## Requirements
- R1: While reset is held and just after it, `busy` and `done` are low and every tile word reads zero.
- R2: During a pass, tile word (r,c) becomes lane(A[r], B[c], old word, pa[r] & pb[c]). Passes accumulate onto the existing tile contents.
- R3: `op[1:0]`=2'b10 selects the byte form. Bytes 0..3 of the products sum into bits 31:0 and bytes 4..7 sum into bits 63:32. Each half wraps modulo 2^32, with no carry or borrow between the halves. `op[1:0]`=2'b11 selects the halfword form: four products sum into the word modulo 2^64.
- R4: `op[2]`=1 treats A elements as unsigned and `op[3]`=1 treats B elements as unsigned. A value of 0 means signed.
- R5: `op[4]`=1 subtracts the product sum from the old word instead of adding it.
- R6: In the byte form, predicate bit i enables byte i of A. In the halfword form, bit 2k enables halfword k of A and the odd bits have no effect. A disabled element counts as zero.
- R7: `busy` rises the cycle after an accepted `start` and stays high for exactly VL×VL cycles. `done` is high for the single cycle after `busy` falls.
- R8: Changes to the vectors, predicates or `op`, and any `start` pulse, have no effect while `busy` is high.
- R9: A `start` whose `op[1]` is 0 (size 2'b00 or 2'b01) is not accepted and leaves the tile unchanged.
- R10: `clr` while idle zeroes the whole tile and takes priority over a `start` in the same cycle. `clr` while busy is ignored.
- R11: `rd_data` shows the tile word at (`rd_row`, `rd_col`) in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass when idle |
| clr | input | 1 | Zero the tile when idle |
| op | input | 5 | [1:0] size, [2] A unsigned, [3] B unsigned, [4] subtract |
| a_vec | input | VL*64 | Row operand vector, word i at bits 64i+63:64i |
| b_vec | input | VL*64 | Column operand vector |
| a_pred | input | VL*8 | Row predicate bytes, byte i for word i |
| b_pred | input | VL*8 | Column predicate bytes |
| rd_row | input | max(1,clog2(VL)) | Read row index |
| rd_col | input | max(1,clog2(VL)) | Read column index |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 64 | Tile word at the read indices |

## Verification
The bench drives all eight signedness and size combinations, then looks at the corner cases.

- **Sign extension:** mixed-sign pairs are run with values at the extremes. A design that sign-extends an operand marked unsigned, or the reverse, returns wrong products.
- **Half independence:** a subtract pass from a zero tile with every byte at 0x80 must give 0xFFFF0000 in both halves. A design whose low half borrows into the high half gets the upper word wrong.
- **Halfword predicates:** predicates with only odd bits set must leave the tile unchanged in the halfword form. A design that takes the predicate bits in pairs, or uses the byte mapping, changes words that should stay the same.
- **Latched inputs:** inputs are scrambled, and `start` and `clr` are pulsed in the middle of a pass. A design that reads live inputs or obeys either control while busy corrupts the tile or restarts the pass.

// File: rtl/outer_tile_mac.sv
module outer_tile_mac #(
  parameter int VL = 4,
  localparam int IW = (VL > 1) ? $clog2(VL) : 1,
  localparam int TW = VL * VL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clr,
  input  logic [4:0]        op,
  input  logic [VL*64-1:0]  a_vec,
  input  logic [VL*64-1:0]  b_vec,
  input  logic [VL*8-1:0]   a_pred,
  input  logic [VL*8-1:0]   b_pred,
  input  logic [IW-1:0]     rd_row,
  input  logic [IW-1:0]     rd_col,
  output logic              busy,
  output logic              done,
  output logic [63:0]       rd_data
);

  logic [63:0] tile [TW];
  logic [63:0] aq [VL];
  logic [63:0] bq [VL];
  logic [7:0]  paq [VL];
  logic [7:0]  pbq [VL];
  logic        half_q, ua_q, ub_q, neg_q;
  logic [IW-1:0] row, col;
  logic [63:0] lane_out;
  int          cur;

  function automatic logic [63:0] lane(
    input logic [63:0] a, b, acc,
    input logic [7:0]  p,
    input logic        half, ua, ub, neg
  );
    logic [31:0]        s0, s1;
    logic [63:0]        sd;
    logic [7:0]         eb;
    logic [15:0]        eh;
    logic signed [8:0]  xa, xb;
    logic signed [17:0] pb;
    logic signed [16:0] ha, hb;
    logic signed [33:0] ph;
    s0 = '0;
    s1 = '0;
    sd = '0;
    for (int i = 0; i < 8; i++) begin
      eb = p[i] ? a[8*i +: 8] : 8'h00;
      xa = {~ua & eb[7], eb};
      xb = {~ub & b[8*i+7], b[8*i +: 8]};
      pb = xa * xb;
      if (i < 4) s0 = s0 + {{14{pb[17]}}, pb};
      else       s1 = s1 + {{14{pb[17]}}, pb};
    end
    for (int k = 0; k < 4; k++) begin
      eh = p[2*k] ? a[16*k +: 16] : 16'h0000;
      ha = {~ua & eh[15], eh};
      hb = {~ub & b[16*k+15], b[16*k +: 16]};
      ph = ha * hb;
      sd = sd + {{30{ph[33]}}, ph};
    end
    if (half)
      lane = neg ? acc - sd : acc + sd;
    else
      lane = {neg ? acc[63:32] - s1 : acc[63:32] + s1,
              neg ? acc[31:0]  - s0 : acc[31:0]  + s0};
  endfunction

  assign cur      = int'(row) * VL + int'(col);
  assign lane_out = lane(aq[row], bq[col], tile[cur], paq[row] & pbq[col],
                         half_q, ua_q, ub_q, neg_q);
  assign rd_data  = tile[int'(rd_row) * VL + int'(rd_col)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      row    <= '0;
      col    <= '0;
      half_q <= 1'b0;
      ua_q   <= 1'b0;
      ub_q   <= 1'b0;
      neg_q  <= 1'b0;
      for (int t = 0; t < TW; t++) tile[t] <= '0;
      for (int i = 0; i < VL; i++) begin
        aq[i]  <= '0;
        bq[i]  <= '0;
        paq[i] <= '0;
        pbq[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (clr) begin
          for (int t = 0; t < TW; t++) tile[t] <= '0;
        end else if (start && op[1]) begin
          busy   <= 1'b1;
          row    <= '0;
          col    <= '0;
          half_q <= op[0];
          ua_q   <= op[2];
          ub_q   <= op[3];
          neg_q  <= op[4];
          for (int i = 0; i < VL; i++) begin
            aq[i]  <= a_vec[64*i +: 64];
            bq[i]  <= b_vec[64*i +: 64];
            paq[i] <= a_pred[8*i +: 8];
            pbq[i] <= b_pred[8*i +: 8];
          end
        end
      end else begin
        tile[cur] <= lane_out;
        if (col == IW'(VL - 1)) begin
          col <= '0;
          if (row == IW'(VL - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            row <= row + 1'b1;
          end
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/outer_tile_mac_chk.sv
module outer_tile_mac_chk #(
  parameter int VL = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        clr,
  input logic [4:0]  op,
  input logic        busy,
  input logic        done,
  input logic [63:0] rd_data
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else        run_len <= busy ? run_len + 1'b1 : '0;
  end

  assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op[1] && !clr) |=> busy);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_run_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (run_len == 32'(VL * VL)));

  assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !op[1]) |=> !busy);

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && clr) |=> !busy);

  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && clr) |=> (rd_data == 64'd0));

endmodule

bind outer_tile_mac outer_tile_mac_chk #(.VL(VL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .op(op),
  .busy(busy), .done(done), .rd_data(rd_data)
);

// File: tb/tb_outer_tile_mac.sv
`timescale 1ns/1ps
module tb_outer_tile_mac;
  localparam int VL = 4;
  localparam int NT = 12;

  localparam logic [4:0] TV_OP [NT] = '{
    5'b00010, 5'b00110, 5'b01010, 5'b01110, 5'b10010, 5'b00011,
    5'b00111, 5'b01011, 5'b11111, 5'b00010, 5'b10011, 5'b01110};
  localparam logic [31:0] TV_PA [NT] = '{
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0F3CA5FF, 32'h55330FF0, 32'hFFFFFFFF};
  localparam logic [31:0] TV_PB [NT] = '{
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hF0FF3C81, 32'hFF00FFFF, 32'h00000000};
  localparam logic [31:0] TV_SEED [NT] = '{
    32'h11, 32'h22, 32'h33, 32'h44, 32'h55, 32'h66,
    32'h77, 32'h88, 32'h99, 32'hAA, 32'hBB, 32'hCC};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, clr = 1'b0;
  logic [4:0] op = '0;
  logic [VL*64-1:0] a_vec = '0, b_vec = '0;
  logic [VL*8-1:0]  a_pred = '0, b_pred = '0;
  logic [1:0] rd_row = '0, rd_col = '0;
  logic busy, done;
  logic [63:0] rd_data;
  logic [63:0] exp_t [VL*VL];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  outer_tile_mac #(.VL(VL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clr(clr), .op(op),
    .a_vec(a_vec), .b_vec(b_vec), .a_pred(a_pred), .b_pred(b_pred),
    .rd_row(rd_row), .rd_col(rd_col), .busy(busy), .done(done), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] gen(input logic [31:0] seed, input int k);
    logic [63:0] x;
    if (seed == 0) return 64'h8080808080808080;
    x = {seed, ~seed} ^ (64'(k + 1) * 64'h9E3779B97F4A7C15);
    x = x ^ (x >> 29);
    x = x * 64'hBF58476D1CE4E5B9;
    x = x ^ (x >> 32);
    return x;
  endfunction

  function automatic logic [63:0] ref_lane(input logic [63:0] a, b, acc,
                                           input logic [7:0] p, input logic [4:0] o);
    int s [2];
    int x, y;
    longint h, hx, hy;
    logic [31:0] lo, hi;
    s[0] = 0; s[1] = 0; h = 0;
    if (!o[0]) begin
      for (int i = 0; i < 8; i++) begin
        x = !p[i] ? 0 : (o[2] ? int'(a[8*i +: 8]) : int'($signed(a[8*i +: 8])));
        y = o[3] ? int'(b[8*i +: 8]) : int'($signed(b[8*i +: 8]));
        s[i/4] += x * y;
      end
      lo = o[4] ? acc[31:0]  - 32'(s[0]) : acc[31:0]  + 32'(s[0]);
      hi = o[4] ? acc[63:32] - 32'(s[1]) : acc[63:32] + 32'(s[1]);
      return {hi, lo};
    end
    for (int k = 0; k < 4; k++) begin
      hx = !p[2*k] ? 0 : (o[2] ? longint'(a[16*k +: 16]) : longint'($signed(a[16*k +: 16])));
      hy = o[3] ? longint'(b[16*k +: 16]) : longint'($signed(b[16*k +: 16]));
      h += hx * hy;
    end
    return o[4] ? acc - 64'(h) : acc + 64'(h);
  endfunction

  task automatic check_tile(input string req);
    for (int r = 0; r < VL; r++)
      for (int c = 0; c < VL; c++) begin
        rd_row = 2'(r);
        rd_col = 2'(c);
        #0.1;
        chk(rd_data === exp_t[r*VL+c], req, rd_data, exp_t[r*VL+c]);
      end
  endtask

  task automatic run_op(input logic [4:0] o, input logic [31:0] pa, input logic [31:0] pb,
                        input logic [31:0] seed, input bit disturb);
    logic [63:0] av [VL];
    logic [63:0] bv [VL];
    int bc;
    for (int i = 0; i < VL; i++) begin
      av[i] = gen(seed, i);
      bv[i] = gen(seed, i + VL);
    end
    @(negedge clk);
    op = o; a_pred = pa; b_pred = pb; start = 1'b1;
    for (int i = 0; i < VL; i++) begin
      a_vec[64*i +: 64] = av[i];
      b_vec[64*i +: 64] = bv[i];
    end
    if (o[1])
      for (int r = 0; r < VL; r++)
        for (int c = 0; c < VL; c++)
          exp_t[r*VL+c] = ref_lane(av[r], bv[c], exp_t[r*VL+c], pa[8*r +: 8] & pb[8*c +: 8], o);
    @(negedge clk);
    start = 1'b0;
    a_vec = ~a_vec; b_vec = {b_vec[63:0], b_vec[VL*64-1:64]};
    a_pred = ~a_pred; op = o ^ 5'b11101;
    if (!o[1]) begin
      chk(busy == 1'b0, "R9 start with bad size", 64'(busy), 64'd0);
      return;
    end
    chk(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
    bc = 1;
    if (disturb) begin start = 1'b1; clr = 1'b1; end
    while (busy) begin
      @(negedge clk);
      start = 1'b0; clr = 1'b0;
      if (busy) bc++;
    end
    chk(done == 1'b1, "R7 done after busy", 64'(done), 64'd1);
    chk(bc == VL*VL, "R7 busy length", 64'(bc), 64'(VL*VL));
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int t = 0; t < VL*VL; t++) exp_t[t] = '0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 outputs in reset", {busy, done}, 64'd0);
    check_tile("R1 R11 tile in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 outputs after reset", {busy, done}, 64'd0);

    for (int t = 0; t < NT; t++) begin
      run_op(TV_OP[t], TV_PA[t], TV_PB[t], TV_SEED[t], 1'b0);
      check_tile("R2 R3 R4 R5 R6 R11 table entry");
    end

    run_op(5'b01011, '1, '1, 32'h1234, 1'b1);
    check_tile("R8 R10 disturbed pass");

    run_op(5'b10001, '1, '1, 32'h77, 1'b0);
    check_tile("R9 tile untouched");

    @(negedge clk);
    clr = 1'b1; start = 1'b1; op = 5'b00010;
    @(negedge clk);
    clr = 1'b0; start = 1'b0;
    chk(busy == 1'b0, "R10 clear beats start", 64'(busy), 64'd0);
    for (int t = 0; t < VL*VL; t++) exp_t[t] = '0;
    check_tile("R10 cleared tile");

    run_op(5'b10010, '1, '1, 32'h0, 1'b0);
    rd_row = 2'd2; rd_col = 2'd1; #0.1;
    chk(rd_data === 64'hFFFF0000FFFF0000, "R3 R5 halves independent", rd_data, 64'hFFFF0000FFFF0000);
    check_tile("R3 R5 wrap pass");

    run_op(5'b00011, 32'hAAAAAAAA, '1, 32'h4321, 1'b0);
    check_tile("R6 odd predicate bits in halfword form");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule